// File: doc/BRIEF.md
# Parameter-Block Diskette Command Engine

This block runs one diskette command at a time. A one-cycle start pulse hands it the 16-bit address of a seven-byte parameter block in system memory. The engine fetches the block over a byte-wide memory master port, decodes the drive unit and the opcode, and validates the request against a double-density geometry of 77 tracks (0 to 76) and 52 sectors of 128 bytes per track. It then carries the command out.

Seek and recalibrate update a per-drive position register. Read and write move whole 128-byte sectors between the system buffer and a byte-addressed disk-image port. Format replicates one fill byte across a full track. Every command ends with a one-cycle done strobe. Result-type and error registers hold the outcome until the next command that updates them. An interrupt strobe accompanies done whenever the completion path raises the interrupt.

Both master ports move one byte per accepted beat. A beat is accepted on a clock edge where the port's request and grant are both high. Read data is taken in that same cycle. While a request waits for its grant, its address, direction and write data stay unchanged.

Top module: `dskcmd_engine`

## Requirements
- R1: After synchronous reset: done, irq and busy are 0, res_type is 2'b10, err_code is 8'h00, every drive position (track and sector) is 0, and neither master port requests.
- R2: On start while idle, the engine reads parameter bytes at pb_addr+0 .. pb_addr+6. Byte 1 is the instruction (bits 2..0 opcode, bits 5..4 unit), byte 2 the record count, byte 3 the track, byte 4 the sector, and bytes 5/6 the buffer address (low byte first). A port request holds its address and direction stable until granted.
- R3: Opcodes are 0 no-op, 1 seek, 2 format, 3 recalibrate, 4 read, 5 verify, 6 write and 7 write-deleted. If drive_ready[unit] is 0, the command ends with res_type 2'b00, err_code 8'h80, irq and no transfer.
- R4: For every opcode except recalibrate, any of these gives res_type 2'b00, err_code 8'h08 and irq: sector 0, sector above 52, sector+count above 53, or track above 76. Recalibrate skips this check.
- R5: Format and write on a unit whose write_prot bit is 1 end with res_type 2'b00, err_code 8'h20 and irq, and write nothing to the image.
- R6: Read copies count records. For each record it moves 128 bytes from image offset (track*52 + sector-1)*128 into the buffer, then advances the sector by one and the buffer by 0x80. A count of 0 completes OK with no transfer.
- R7: Write moves bytes in the opposite direction, from the buffer to the image, with the same offsets and stepping as read.
- R8: Format reads one fill byte at the buffer address and writes it to 6656 (52*128) consecutive image bytes starting at the computed offset.
- R9: Seek loads the unit's position with the track and sector. Recalibrate loads track 0 and the given sector. No other command changes any position.
- R10: A successful command ends with res_type 2'b10, err_code 8'h00 and irq. No-op and verify do this with no transfer.
- R11: Opcode 7 ends with done but no irq, and leaves res_type and err_code unchanged.
- R12: Each command gives exactly one done pulse, one cycle wide. irq is high only together with done. A start pulse while busy is ignored.
- R13: The checks run in a fixed priority order: not-ready first, then address error, then write protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only while idle |
| pb_addr | input | 16 | Parameter block address |
| drive_ready | input | NUM_DRV | Per-unit ready level |
| write_prot | input | NUM_DRV | Per-unit write-protect level |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with grant |
| mem_gnt | input | 1 | Memory grant |
| img_req | output | 1 | Image beat request |
| img_we | output | 1 | Image beat is a write |
| img_addr | output | IMG_AW | Image byte offset |
| img_wdata | output | 8 | Image write byte |
| img_rdata | input | 8 | Image read byte, valid with grant |
| img_gnt | input | 1 | Image grant |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion strobe |
| irq | output | 1 | Interrupt strobe, only with done |
| res_type | output | 2 | Result type (00 error, 10 OK) |
| err_code | output | 8 | Error byte |
| pos_track | output | NUM_DRV*8 | Track position per unit, unit u at [8u+7:8u] |
| pos_sector | output | NUM_DRV*8 | Sector position per unit, unit u at [8u+7:8u] |

## Verification
The hardest cases to reach are a grant that drops in the middle of a sector burst, and a start pulse that arrives while a transfer is running. Both ports are driven by grant patterns from a free-running counter, with different periods for the two ports, so stalls land on fetch beats, staging beats and record boundaries alike. Every image or buffer byte written is compared on the fly against an address-derived pattern. A second start is pulsed in the middle of a two-record read, using a parameter block that would move a drive. The bench then confirms that only one done appears and that the drive position is untouched.

// File: rtl/dskcmd_pkg.sv
package dskcmd_pkg;

    localparam int PB_AW      = 16;
    localparam int SEC_BYTES  = 128;
    localparam int SEC_PER_TRK = 52;
    localparam int LAST_TRK   = 76;
    localparam int TRK_BYTES  = SEC_BYTES * SEC_PER_TRK;
    localparam int FCNT_W     = $clog2(TRK_BYTES);
    localparam int BIDX_W     = $clog2(SEC_BYTES);

    localparam logic [1:0] RT_ERR = 2'b00;
    localparam logic [1:0] RT_OK  = 2'b10;
    localparam logic [7:0] EC_NOTRDY = 8'h80;
    localparam logic [7:0] EC_ADDR   = 8'h08;
    localparam logic [7:0] EC_WPROT  = 8'h20;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_SEEK   = 3'd1,
        OP_FMT    = 3'd2,
        OP_RECAL  = 3'd3,
        OP_READ   = 3'd4,
        OP_VERIFY = 3'd5,
        OP_WRITE  = 3'd6,
        OP_WDEL   = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        OC_GO, OC_NOTRDY, OC_ADDR, OC_WPROT
    } outcome_e;

    typedef struct packed {
        opcode_e    op;
        logic [1:0] unit;
        logic [7:0] count;
        logic [7:0] track;
        logic [7:0] sector;
        logic [PB_AW-1:0] buf_addr;
    } cmd_t;

    function automatic logic geom_bad(input logic [7:0] count,
                                      input logic [7:0] track,
                                      input logic [7:0] sector);
        logic [8:0] span;
        span = {1'b0, sector} + {1'b0, count};
        return (sector == 8'd0) || (sector > 8'(SEC_PER_TRK)) ||
               (span > 9'(SEC_PER_TRK + 1)) || (track > 8'(LAST_TRK));
    endfunction

endpackage

// File: rtl/dcmd_validate.sv
module dcmd_validate
    import dskcmd_pkg::*;
#(
    parameter int NUM_DRV = 4
) (
    input  cmd_t               cmd,
    input  logic [NUM_DRV-1:0] drive_ready,
    input  logic [NUM_DRV-1:0] write_prot,
    output outcome_e           outcome
);
    logic rdy, prot, writes_media, skip_geom;

    assign rdy          = drive_ready[cmd.unit];
    assign prot         = write_prot[cmd.unit];
    assign writes_media = (cmd.op == OP_FMT) || (cmd.op == OP_WRITE);
    assign skip_geom    = (cmd.op == OP_RECAL);

    // priority: readiness, then geometry, then protection
    always_comb begin
        if (!rdy)
            outcome = OC_NOTRDY;
        else if (!skip_geom && geom_bad(cmd.count, cmd.track, cmd.sector))
            outcome = OC_ADDR;
        else if (writes_media && prot)
            outcome = OC_WPROT;
        else
            outcome = OC_GO;
    end
endmodule

// File: rtl/dcmd_posreg.sv
module dcmd_posreg #(
    parameter int NUM_DRV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_unit,
    input  logic [7:0]           wr_track,
    input  logic [7:0]           wr_sector,
    output logic [NUM_DRV*8-1:0] trk_q,
    output logic [NUM_DRV*8-1:0] sec_q
);
    for (genvar u = 0; u < NUM_DRV; u++) begin : g_drv
        always_ff @(posedge clk) begin
            if (rst) begin
                trk_q[u*8 +: 8] <= '0;
                sec_q[u*8 +: 8] <= '0;
            end else if (wr_en && (wr_unit == 2'(u))) begin
                trk_q[u*8 +: 8] <= wr_track;
                sec_q[u*8 +: 8] <= wr_sector;
            end
        end
    end

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(trk_q) && $stable(sec_q)); // R9
endmodule

// File: rtl/dcmd_imgaddr.sv
module dcmd_imgaddr
    import dskcmd_pkg::*;
#(
    parameter int IMG_AW = 19
) (
    input  logic [7:0]        track,
    input  logic [7:0]        sector,
    input  logic [FCNT_W-1:0] boff,
    output logic [IMG_AW-1:0] addr
);
    logic [IMG_AW-1:0] trk_part, sec_part;

    assign trk_part = IMG_AW'(track) * IMG_AW'(TRK_BYTES);
    assign sec_part = (IMG_AW'(sector) - IMG_AW'(1)) * IMG_AW'(SEC_BYTES);
    assign addr     = trk_part + sec_part + IMG_AW'(boff);
endmodule

// File: rtl/dskcmd_engine.sv
module dskcmd_engine
    import dskcmd_pkg::*;
#(
    parameter int IMG_AW  = 19,
    parameter int NUM_DRV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [15:0]          pb_addr,
    input  logic [NUM_DRV-1:0]   drive_ready,
    input  logic [NUM_DRV-1:0]   write_prot,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [15:0]          mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata,
    input  logic                 mem_gnt,
    output logic                 img_req,
    output logic                 img_we,
    output logic [IMG_AW-1:0]    img_addr,
    output logic [7:0]           img_wdata,
    input  logic [7:0]           img_rdata,
    input  logic                 img_gnt,
    output logic                 busy,
    output logic                 done,
    output logic                 irq,
    output logic [1:0]           res_type,
    output logic [7:0]           err_code,
    output logic [NUM_DRV*8-1:0] pos_track,
    output logic [NUM_DRV*8-1:0] pos_sector
);
    localparam int PB_LAST = 6;
    localparam logic [FCNT_W-1:0] FMT_LAST = FCNT_W'(TRK_BYTES - 1);
    localparam logic [BIDX_W-1:0] SEC_LAST = BIDX_W'(SEC_BYTES - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_FILL, S_FMT, S_SRC, S_DST
    } state_e;

    state_e            state;
    cmd_t              cmd;
    logic [15:0]       base;
    logic [2:0]        idx;
    logic [7:0]        cur_sector, rec_left;
    logic [15:0]       cur_buf;
    logic [BIDX_W-1:0] bidx;
    logic [FCNT_W-1:0] fcnt;
    logic [7:0]        hold;
    outcome_e          outcome;

    logic rd_op, src_gnt, dst_gnt;
    logic fin, fin_irq, fin_upd;
    logic [1:0] fin_type;
    logic [7:0] fin_err;
    logic pos_we;
    logic [7:0] pos_trk_in;
    logic [FCNT_W-1:0] img_boff;

    dcmd_validate #(.NUM_DRV(NUM_DRV)) u_val (
        .cmd(cmd), .drive_ready(drive_ready), .write_prot(write_prot),
        .outcome(outcome)
    );

    dcmd_imgaddr #(.IMG_AW(IMG_AW)) u_addr (
        .track(cmd.track), .sector(cur_sector), .boff(img_boff), .addr(img_addr)
    );

    assign pos_we     = (state == S_CHECK) && (outcome == OC_GO) &&
                        ((cmd.op == OP_SEEK) || (cmd.op == OP_RECAL));
    assign pos_trk_in = (cmd.op == OP_RECAL) ? 8'd0 : cmd.track;

    dcmd_posreg #(.NUM_DRV(NUM_DRV)) u_pos (
        .clk(clk), .rst(rst), .wr_en(pos_we), .wr_unit(cmd.unit),
        .wr_track(pos_trk_in), .wr_sector(cmd.sector),
        .trk_q(pos_track), .sec_q(pos_sector)
    );

    // port steering
    assign rd_op     = (cmd.op == OP_READ);
    assign busy      = (state != S_IDLE);
    assign mem_req   = (state == S_FETCH) || (state == S_FILL) ||
                       ((state == S_SRC) && !rd_op) || ((state == S_DST) && rd_op);
    assign mem_we    = (state == S_DST) && rd_op;
    assign mem_wdata = hold;
    assign img_req   = (state == S_FMT) || ((state == S_SRC) && rd_op) ||
                       ((state == S_DST) && !rd_op);
    assign img_we    = (state == S_FMT) || ((state == S_DST) && !rd_op);
    assign img_wdata = hold;
    assign img_boff  = (state == S_FMT) ? fcnt : FCNT_W'(bidx);
    assign src_gnt   = rd_op ? img_gnt : mem_gnt;
    assign dst_gnt   = rd_op ? mem_gnt : img_gnt;

    always_comb begin
        unique case (state)
            S_FETCH: mem_addr = base + 16'(idx);
            S_FILL:  mem_addr = cmd.buf_addr;
            default: mem_addr = cur_buf + 16'(bidx);
        endcase
    end

    // completion decode
    always_comb begin
        fin = 1'b0; fin_irq = 1'b1; fin_upd = 1'b1;
        fin_type = RT_OK; fin_err = 8'h00;
        unique case (state)
            S_CHECK: begin
                if (outcome != OC_GO) begin
                    fin = 1'b1;
                    fin_type = RT_ERR;
                    unique case (outcome)
                        OC_NOTRDY: fin_err = EC_NOTRDY;
                        OC_ADDR:   fin_err = EC_ADDR;
                        default:   fin_err = EC_WPROT;
                    endcase
                end else begin
                    unique case (cmd.op)
                        OP_FMT:  fin = 1'b0;
                        OP_READ, OP_WRITE: fin = (cmd.count == 8'd0);
                        OP_WDEL: begin fin = 1'b1; fin_irq = 1'b0; fin_upd = 1'b0; end
                        default: fin = 1'b1;
                    endcase
                end
            end
            S_FMT:   fin = img_gnt && (fcnt == FMT_LAST);
            S_DST:   fin = dst_gnt && (bidx == SEC_LAST) && (rec_left == 8'd1);
            default: fin = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        irq  <= 1'b0;
        if (rst) begin
            state      <= S_IDLE;
            cmd        <= '0;
            base       <= '0;
            idx        <= '0;
            cur_sector <= '0;
            rec_left   <= '0;
            cur_buf    <= '0;
            bidx       <= '0;
            fcnt       <= '0;
            hold       <= '0;
            res_type   <= RT_OK;
            err_code   <= 8'h00;
        end else if (fin) begin
            done  <= 1'b1;
            irq   <= fin_irq;
            state <= S_IDLE;
            if (fin_upd) begin
                res_type <= fin_type;
                err_code <= fin_err;
            end
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    base  <= pb_addr;
                    idx   <= '0;
                    state <= S_FETCH;
                end
                S_FETCH: if (mem_gnt) begin
                    unique case (idx)
                        3'd1: begin
                            cmd.op   <= opcode_e'(mem_rdata[2:0]);
                            cmd.unit <= mem_rdata[5:4];
                        end
                        3'd2: cmd.count  <= mem_rdata;
                        3'd3: cmd.track  <= mem_rdata;
                        3'd4: cmd.sector <= mem_rdata;
                        3'd5: cmd.buf_addr[7:0]  <= mem_rdata;
                        3'd6: cmd.buf_addr[15:8] <= mem_rdata;
                        default: ;
                    endcase
                    if (idx == 3'(PB_LAST)) state <= S_CHECK;
                    else                    idx   <= idx + 3'd1;
                end
                S_CHECK: begin
                    cur_sector <= cmd.sector;
                    cur_buf    <= cmd.buf_addr;
                    rec_left   <= cmd.count;
                    bidx       <= '0;
                    fcnt       <= '0;
                    state      <= (cmd.op == OP_FMT) ? S_FILL : S_SRC;
                end
                S_FILL: if (mem_gnt) begin
                    hold  <= mem_rdata;
                    state <= S_FMT;
                end
                S_FMT: if (img_gnt) fcnt <= fcnt + FCNT_W'(1);
                S_SRC: if (src_gnt) begin
                    hold  <= rd_op ? img_rdata : mem_rdata;
                    state <= S_DST;
                end
                S_DST: if (dst_gnt) begin
                    state <= S_SRC;
                    if (bidx == SEC_LAST) begin
                        bidx       <= '0;
                        rec_left   <= rec_left - 8'd1;
                        cur_sector <= cur_sector + 8'd1;
                        cur_buf    <= cur_buf + 16'(SEC_BYTES);
                    end else begin
                        bidx <= bidx + BIDX_W'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !img_req); // R1
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
    AST_IMG_HOLD: assert property (@(posedge clk) disable iff (rst)
        img_req && !img_gnt |=> img_req && $stable(img_addr) && $stable(img_we)); // R2
    AST_ERR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        done && res_type == RT_ERR |-> $countones(err_code) == 1); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> done); // R12
    AST_SILENT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        done && !irq |-> $stable(res_type) && $stable(err_code)); // R11
endmodule

// File: tb/tb_dskcmd_engine.sv
`timescale 1ns/1ps
module tb_dskcmd_engine;
    localparam int IMG_AW = 19;
    localparam int NUM_DRV = 4;
    localparam logic [15:0] PB_BASE = 16'h0100;

    typedef struct packed {
        logic [1:0] unit; logic [2:0] op; logic [7:0] cnt; logic [7:0] trk;
        logic [7:0] sec; logic [3:0] rdy; logic [3:0] wp; logic [1:0] et;
        logic [7:0] ee; logic eirq; logic [15:0] iw; logic [15:0] mw;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 8'd0,   8'd0,  8'd1,  4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd0,    16'd0},
        '{2'd1, 3'd4, 8'd1,   8'd0,  8'd1,  4'hD, 4'h0, 2'b00, 8'h80, 1'b1, 16'd0,    16'd0},
        '{2'd0, 3'd4, 8'd1,   8'd0,  8'd0,  4'hF, 4'h0, 2'b00, 8'h08, 1'b1, 16'd0,    16'd0},
        '{2'd0, 3'd4, 8'd1,   8'd0,  8'd53, 4'hF, 4'h0, 2'b00, 8'h08, 1'b1, 16'd0,    16'd0},
        '{2'd0, 3'd4, 8'd4,   8'd10, 8'd50, 4'hF, 4'h0, 2'b00, 8'h08, 1'b1, 16'd0,    16'd0},
        '{2'd0, 3'd4, 8'd3,   8'd10, 8'd50, 4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd0,    16'd384},
        '{2'd0, 3'd4, 8'd1,   8'd77, 8'd1,  4'hF, 4'h0, 2'b00, 8'h08, 1'b1, 16'd0,    16'd0},
        '{2'd1, 3'd4, 8'd2,   8'd76, 8'd51, 4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd0,    16'd256},
        '{2'd2, 3'd6, 8'd1,   8'd5,  8'd3,  4'hF, 4'h4, 2'b00, 8'h20, 1'b1, 16'd0,    16'd0},
        '{2'd2, 3'd7, 8'd1,   8'd5,  8'd3,  4'hF, 4'h0, 2'b00, 8'h20, 1'b0, 16'd0,    16'd0},
        '{2'd2, 3'd6, 8'd2,   8'd5,  8'd3,  4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd256,  16'd0},
        '{2'd3, 3'd2, 8'd1,   8'd76, 8'd1,  4'hF, 4'h8, 2'b00, 8'h20, 1'b1, 16'd0,    16'd0},
        '{2'd3, 3'd2, 8'd1,   8'd76, 8'd1,  4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd6656, 16'd0},
        '{2'd0, 3'd5, 8'd5,   8'd0,  8'd1,  4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd0,    16'd0},
        '{2'd0, 3'd4, 8'd0,   8'd3,  8'd7,  4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd0,    16'd0},
        '{2'd2, 3'd4, 8'd1,   8'd200,8'd0,  4'hB, 4'h0, 2'b00, 8'h80, 1'b1, 16'd0,    16'd0},
        '{2'd1, 3'd2, 8'd1,   8'd90, 8'd1,  4'hF, 4'h2, 2'b00, 8'h08, 1'b1, 16'd0,    16'd0},
        '{2'd0, 3'd3, 8'd0,   8'd99, 8'd0,  4'hF, 4'h0, 2'b10, 8'h00, 1'b1, 16'd0,    16'd0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 13: return "R10";
            1:     return "R3";
            2, 3, 4, 6, 17: return "R4";
            5, 7, 14: return "R6";
            8, 11: return "R5";
            9:     return "R11";
            10:    return "R7";
            12:    return "R8";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [7:0] mp(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] ip(input logic [18:0] x);
        return x[7:0] + x[15:8] + {5'b0, x[18:16]} + 8'h3C;
    endfunction

    logic clk = 0, rst = 1, start = 0;
    logic [15:0] pb_addr = PB_BASE;
    logic [3:0] drv_rdy = 4'hF, drv_wp = 4'h0;
    logic mem_req, mem_we, mem_gnt, img_req, img_we, img_gnt;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, img_wdata, img_rdata;
    logic [IMG_AW-1:0] img_addr;
    logic busy, done, irq;
    logic [1:0] res_type;
    logic [7:0] err_code;
    logic [NUM_DRV*8-1:0] pos_track, pos_sector;

    always #4 clk = ~clk;

    dskcmd_engine #(.IMG_AW(IMG_AW), .NUM_DRV(NUM_DRV)) dut (
        .clk(clk), .rst(rst), .start(start), .pb_addr(pb_addr),
        .drive_ready(drv_rdy), .write_prot(drv_wp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
        .img_req(img_req), .img_we(img_we), .img_addr(img_addr),
        .img_wdata(img_wdata), .img_rdata(img_rdata), .img_gnt(img_gnt),
        .busy(busy), .done(done), .irq(irq), .res_type(res_type),
        .err_code(err_code), .pos_track(pos_track), .pos_sector(pos_sector)
    );

    // memories and grant patterns
    logic [7:0] pbm [0:7];
    logic [15:0] rel;
    logic [7:0] stall_cnt = 0;
    always @(posedge clk) stall_cnt <= stall_cnt + 8'd1;
    assign mem_gnt   = (stall_cnt[1:0] != 2'd3);
    assign img_gnt   = (stall_cnt[2:0] != 3'd5);
    assign rel       = mem_addr - PB_BASE;
    assign mem_rdata = (rel < 16'd7) ? pbm[rel[2:0]] : mp(mem_addr);
    assign img_rdata = ip(img_addr);

    int checks = 0, fails = 0;
    int iw_cnt, mw_cnt, mism, done_cnt;
    logic [18:0] iw_first, iw_last, exp_off;
    logic [15:0] mw_first, exp_buf;
    logic fmt_mode;
    logic [7:0] fill_exp;

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (mem_req && mem_gnt && mem_we) begin
            if (mw_cnt == 0) mw_first = mem_addr;
            mw_cnt++;
            if (mem_wdata != ip(exp_off + 19'(mem_addr - exp_buf))) mism++;
        end
        if (img_req && img_gnt && img_we) begin
            if (iw_cnt == 0) iw_first = img_addr;
            iw_last = img_addr;
            iw_cnt++;
            if (img_wdata != (fmt_mode ? fill_exp : mp(exp_buf + 16'(img_addr - exp_off)))) mism++;
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic load_pb(input logic [1:0] unit, input logic [2:0] op,
                           input logic [7:0] cnt, input logic [7:0] trk,
                           input logic [7:0] sec, input logic [15:0] bufa);
        pbm[0] = 8'h00; pbm[1] = {2'b00, unit, 1'b0, op}; pbm[2] = cnt;
        pbm[3] = trk;   pbm[4] = sec; pbm[5] = bufa[7:0]; pbm[6] = bufa[15:8];
        pbm[7] = 8'h00;
        exp_buf  = bufa;
        exp_off  = 19'((int'(trk) * 52 + int'(sec) - 1) * 128);
        fmt_mode = (op == 3'd2);
        fill_exp = mp(bufa);
        iw_cnt = 0; mw_cnt = 0; mism = 0; done_cnt = 0;
    endtask

    task automatic pulse_and_wait(input string tag);
        int n;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done, tag, "done seen", int'(done), 1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        iw_cnt = 0; mw_cnt = 0; mism = 0; done_cnt = 0; fmt_mode = 0;
        exp_buf = 0; exp_off = 0; fill_exp = 0;
        for (int k = 0; k < 8; k++) pbm[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !irq && !busy, "R1", "strobes/busy", {done, irq, busy}, 0);
        chk(res_type == 2'b10, "R1", "res_type", res_type, 2);
        chk(err_code == 8'h00, "R1", "err_code", err_code, 0);
        chk(pos_track == '0 && pos_sector == '0, "R1", "positions", pos_track, 0);
        chk(!mem_req && !img_req, "R1", "requests", {mem_req, img_req}, 0);

        // table walk: decode (R2), checks and transfers
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VEC[i];
            t = tag_of(i);
            drv_rdy = v.rdy; drv_wp = v.wp;
            load_pb(v.unit, v.op, v.cnt, v.trk, v.sec, 16'h4000 + 16'(i * 40));
            pulse_and_wait(t);
            chk(res_type == v.et, t, "res_type", res_type, v.et);
            chk(err_code == v.ee, t, "err_code", err_code, v.ee);
            chk(irq == v.eirq, t, "irq", irq, v.eirq);
            @(negedge clk); @(negedge clk);
            chk(iw_cnt == int'(v.iw), t, "image writes", iw_cnt, v.iw);
            chk(mw_cnt == int'(v.mw), t, "buffer writes", mw_cnt, v.mw);
            chk(mism == 0, t, "data mismatches", mism, 0);
            chk(done_cnt == 1, "R12", "done pulses", done_cnt, 1);
            if (v.iw != 0) begin
                chk(iw_first == exp_off, t, "first image addr", iw_first, exp_off);
                chk(iw_last == exp_off + 19'(v.iw) - 19'd1, t, "last image addr",
                    iw_last, exp_off + 19'(v.iw) - 19'd1);
            end
            if (v.mw != 0)
                chk(mw_first == exp_buf, t, "first buffer addr", mw_first, exp_buf);
        end

        // R9 seek and recalibrate positions
        drv_rdy = 4'hF; drv_wp = 4'h0;
        load_pb(2'd1, 3'd1, 8'd1, 8'd40, 8'd7, 16'h5000);
        pulse_and_wait("R9");
        @(negedge clk);
        chk(pos_track[15:8] == 8'd40, "R9", "seek track", pos_track[15:8], 40);
        chk(pos_sector[15:8] == 8'd7, "R9", "seek sector", pos_sector[15:8], 7);
        load_pb(2'd1, 3'd3, 8'd0, 8'd60, 8'd9, 16'h5000);
        pulse_and_wait("R9");
        @(negedge clk);
        chk(pos_track[15:8] == 8'd0, "R9", "recal track", pos_track[15:8], 0);
        chk(pos_sector[15:8] == 8'd9, "R9", "recal sector", pos_sector[15:8], 9);
        chk(pos_track[7:0] == 8'd0 && pos_track[31:16] == '0, "R9", "other units",
            pos_track, 0);

        // R12 start while busy is ignored
        load_pb(2'd0, 3'd4, 8'd2, 8'd1, 8'd1, 16'h6000);
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        repeat (40) @(negedge clk);
        pbm[1] = {2'b00, 2'd3, 1'b0, 3'd1}; pbm[3] = 8'd11; pbm[4] = 8'd2;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        begin
            int n;
            n = 0;
            while (!done && n < 20000) begin @(negedge clk); n++; end
        end
        repeat (40) @(negedge clk);
        chk(done_cnt == 1, "R12", "done count busy start", done_cnt, 1);
        chk(pos_track[31:24] == 8'd0, "R12", "unit3 track untouched", pos_track[31:24], 0);
        chk(mw_cnt == 256 && mism == 0, "R6", "two-record read", mw_cnt, 256);
        chk(!busy, "R12", "idle after", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule